// File: doc/BRIEF.md
# Read Completion Coalescer

This block sits between the memory read-return path and the completion transmitter of a PCIe root port. Memory returns read data as 64-byte beats. Each beat carries a request tag and a marker on the final beat of its request. The block stores up to four beats and regroups them into completions of one, two or four beats. It then streams each completion out one beat at a time. The first beat of a completion carries the byte count, and the final beat is flagged.

Three setting bits control the grouping. The merge bit allows completions longer than one beat. The wide bit raises the merge ceiling from 128 to 256 bytes. The wait bit makes the block hold data until a full group, or the end of the request, is buffered. Without the wait bit, the block sends whatever is buffered when the sink is ready.

The block keeps its own copy of the three bits. That copy clears on reset. It follows the input pins only while no completion is being sent, so a completion is always built under one setting.

Top module: `rd_cpl_coalescer`

## Requirements
- R1: After reset, out_valid and out_sop are 0, in_ready is 1, and the held setting bits are all 0.
- R2: With the merge bit at 0, every completion is a single beat and reports out_bytes = 64.
- R3: With the merge bit at 1 and the wide bit at 0, a completion holds at most two beats (128 bytes).
- R4: With the merge bit at 1 and the wide bit at 1, a completion holds at most four beats (256 bytes).
- R5: With the wait bit at 0, a completion starts as soon as out_ready is high and a beat is buffered. Its size is the number of buffered beats, capped by the limit and by the end of the request.
- R6: With the wait bit at 1, no completion starts until the limit number of beats is buffered or the final beat of the request is buffered.
- R7: A completion never extends past the final beat of a request. A beat marked last is always sent with out_eop = 1.
- R8: out_bytes equals 64 times the number of beats from the out_sop beat to the out_eop beat. out_bytes and out_tag hold steady across the whole completion.
- R9: Changes to the setting pins while a completion is being sent have no effect on that completion. They apply only to completions decided after it ends.
- R10: The buffer holds four beats. in_ready drops to 0 when it is full. Beats leave in the order they arrived, with their data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_merge | input | 1 | Allow completions longer than one beat |
| cfg_wide | input | 1 | Raise the merge limit from 128 B to 256 B |
| cfg_wait | input | 1 | Hold data until a full group or the request end is buffered |
| in_valid | input | 1 | Read-return beat valid |
| in_ready | output | 1 | Buffer can accept a beat |
| in_tag | input | TAG_W | Request tag of the beat |
| in_last | input | 1 | Final beat of the request |
| in_data | input | DATA_W | 64-byte beat payload |
| out_valid | output | 1 | Completion beat valid |
| out_ready | input | 1 | Sink accepts a beat |
| out_sop | output | 1 | First beat of a completion |
| out_eop | output | 1 | Final beat of a completion |
| out_bytes | output | BW | Byte count of the current completion |
| out_tag | output | TAG_W | Tag of the current completion |
| out_data | output | DATA_W | Completion beat payload |

## Verification
The hardest case to reach is a setting change that lands while a completion is partly sent. To create it, the bench fills the buffer while the sink stalls, then releases the sink. It flips the pins one cycle after the first beat is accepted. The bench then checks that the 256-byte completion already under way finishes unchanged. Finally, it loads a new request while the block is idle, and that request must be split under the new setting. The hold-for-data mode also needs care. Beats are spaced several cycles apart while the sink stays ready, and the bench checks that nothing leaves until the group is complete.

// File: rtl/rd_cpl_coalescer.sv
module rd_cpl_coalescer #(
  parameter int DATA_W     = 512,
  parameter int TAG_W      = 8,
  parameter int BEAT_BYTES = 64,
  parameter int MAX_BEATS  = 4,
  localparam int PW = $clog2(MAX_BEATS),
  localparam int CW = $clog2(MAX_BEATS + 1),
  localparam int BW = $clog2(MAX_BEATS * BEAT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_merge,
  input  logic              cfg_wide,
  input  logic              cfg_wait,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic              in_last,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sop,
  output logic              out_eop,
  output logic [BW-1:0]     out_bytes,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DATA_W-1:0] out_data
);

  logic [DATA_W-1:0] mem_data [MAX_BEATS];
  logic [TAG_W-1:0]  mem_tag  [MAX_BEATS];
  logic [MAX_BEATS-1:0] mem_last;
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt, n_q, sent_q, lim, run, take;
  logic merge_q, wide_q, wait_q, busy, has_last, go, push, pop;

  assign lim = !merge_q ? CW'(1) : (wide_q ? CW'(MAX_BEATS) : CW'(MAX_BEATS / 2));

  always_comb begin
    run = cnt;
    has_last = 1'b0;
    for (int i = 0; i < MAX_BEATS; i++) begin
      if (!has_last && CW'(i) < cnt && mem_last[rd_ptr + PW'(i)]) begin
        has_last = 1'b1;
        run = CW'(i + 1);
      end
    end
  end

  assign take = (run < lim) ? run : lim;
  assign go   = !busy && out_ready && (cnt != '0) && (!wait_q || has_last || cnt >= lim);

  assign in_ready  = cnt < CW'(MAX_BEATS);
  assign push      = in_valid && in_ready;
  assign out_valid = busy;
  assign pop       = out_valid && out_ready;
  assign out_sop   = busy && (sent_q == '0);
  assign out_eop   = busy && (sent_q == n_q - CW'(1));
  assign out_bytes = BW'(n_q) * BW'(BEAT_BYTES);
  assign out_tag   = mem_tag[rd_ptr];
  assign out_data  = mem_data[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) begin
      mem_data[wr_ptr] <= in_data;
      mem_tag[wr_ptr]  <= in_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      cnt      <= '0;
      mem_last <= '0;
      busy     <= 1'b0;
      n_q      <= '0;
      sent_q   <= '0;
      merge_q  <= 1'b0;
      wide_q   <= 1'b0;
      wait_q   <= 1'b0;
    end else begin
      if (push) begin
        mem_last[wr_ptr] <= in_last;
        wr_ptr <= wr_ptr + PW'(1);
      end
      if (pop) rd_ptr <= rd_ptr + PW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
      if (!busy) begin
        merge_q <= cfg_merge;
        wide_q  <= cfg_wide;
        wait_q  <= cfg_wait;
      end
      if (go) begin
        busy   <= 1'b1;
        n_q    <= take;
        sent_q <= '0;
      end else if (pop) begin
        if (out_eop) busy <= 1'b0;
        sent_q <= sent_q + CW'(1);
      end
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX_BEATS));

  // R2
  single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy) && !$past(merge_q)) |-> out_bytes == BW'(BEAT_BYTES));

  // R3
  half_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy) && $past(merge_q) && !$past(wide_q)) |-> n_q <= CW'(MAX_BEATS / 2));

  // R6
  hold_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy) && $past(wait_q)) |-> $past(has_last || cnt >= lim));

  // R7
  end_of_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mem_last[rd_ptr]) |-> out_eop);

  // R8
  steady_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !out_eop) |=> ($stable(out_bytes) && $stable(out_tag) && out_valid));

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(merge_q) && $stable(wide_q) && $stable(wait_q)));

endmodule

// File: tb/rd_cpl_coalescer_tb.sv
module rd_cpl_coalescer_tb_top;
  localparam int DATA_W = 512;
  localparam int TAG_W  = 8;
  localparam int BW     = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_merge = 0, cfg_wide = 0, cfg_wait = 0;
  logic in_valid = 0, in_last = 0, out_ready = 0;
  logic [TAG_W-1:0] in_tag = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, out_valid, out_sop, out_eop;
  logic [BW-1:0] out_bytes;
  logic [TAG_W-1:0] out_tag;
  logic [DATA_W-1:0] out_data;

  int errors = 0, checks = 0;
  int nrec = 0, npush = 0, cyc = 0;
  int rec_bytes [64];
  int rec_tag   [64];
  int rec_data  [64];
  bit rec_sop   [64];
  bit rec_eop   [64];
  int exp_data  [64];
  int exp_tag   [64];

  always #4 clk = ~clk;

  rd_cpl_coalescer #(.DATA_W(DATA_W), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_merge(cfg_merge), .cfg_wide(cfg_wide), .cfg_wait(cfg_wait),
    .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag), .in_last(in_last), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop), .out_eop(out_eop),
    .out_bytes(out_bytes), .out_tag(out_tag), .out_data(out_data));

  always @(negedge clk) begin
    #1;
    if (out_valid && out_ready && nrec < 64) begin
      rec_bytes[nrec] = int'(out_bytes);
      rec_tag[nrec]   = int'(out_tag);
      rec_data[nrec]  = int'(out_data[31:0]);
      rec_sop[nrec]   = out_sop;
      rec_eop[nrec]   = out_eop;
      nrec++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear();
    nrec = 0;
    npush = 0;
  endtask

  task automatic push(input int tag, input bit last);
    @(negedge clk);
    in_valid = 1'b1;
    in_tag   = TAG_W'(tag);
    in_last  = last;
    in_data  = DATA_W'((tag << 16) | npush);
    exp_data[npush] = (tag << 16) | npush;
    exp_tag[npush]  = tag;
    npush++;
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic verify(input string req, input int nc, input int s0, input int s1,
                        input int s2, input int s3);
    int sz [4];
    int p = 0;
    sz[0] = s0; sz[1] = s1; sz[2] = s2; sz[3] = s3;
    for (int k = 0; k < nc; k++) begin
      for (int b = 0; b < sz[k]; b++) begin
        chk(p < nrec, req, nrec, p + 1);
        if (p < nrec) begin
          chk(rec_sop[p] == (b == 0), req, int'(rec_sop[p]), int'(b == 0));
          chk(rec_eop[p] == (b == sz[k] - 1), req, int'(rec_eop[p]), int'(b == sz[k] - 1));
          chk(rec_bytes[p] == sz[k] * 64, req, rec_bytes[p], sz[k] * 64);
          chk(rec_data[p] == exp_data[p], req, rec_data[p], exp_data[p]);
          chk(rec_tag[p] == exp_tag[p], req, rec_tag[p], exp_tag[p]);
        end
        p++;
      end
    end
    chk(nrec == p, req, nrec, p);
  endtask

  task automatic t_reset();
    chk(out_valid == 0, "R1 out_valid", int'(out_valid), 0);
    chk(out_sop == 0, "R1 out_sop", int'(out_sop), 0);
    chk(in_ready == 1, "R1 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_batch(input string req, input bit m, input bit w, input int nb,
                         input int nc, input int s0, input int s1, input int s2, input int s3);
    clear();
    out_ready = 0;
    cfg_merge = m; cfg_wide = w; cfg_wait = 0;
    idle(2);
    for (int i = 0; i < nb; i++) push(3, i == nb - 1);
    if (nb == 4) chk(in_ready == 0, "R10 full", int'(in_ready), 0);
    out_ready = 1;
    idle(16);
    verify(req, nc, s0, s1, s2, s3);
  endtask

  task automatic t_end_of_req();
    clear();
    out_ready = 0;
    cfg_merge = 1; cfg_wide = 1; cfg_wait = 0;
    idle(2);
    push(5, 0); push(5, 0); push(5, 1); push(6, 1);
    out_ready = 1;
    idle(16);
    verify("R7 request end", 2, 3, 1, 0, 0);
  endtask

  task automatic t_stream();
    clear();
    cfg_merge = 1; cfg_wide = 1; cfg_wait = 0;
    out_ready = 1;
    idle(2);
    for (int i = 0; i < 4; i++) begin
      push(7, i == 3);
      idle(4);
    end
    verify("R5 forward", 4, 1, 1, 1, 1);
  endtask

  task automatic t_hold(input int nb);
    clear();
    cfg_merge = 1; cfg_wide = 1; cfg_wait = 1;
    out_ready = 1;
    idle(2);
    for (int i = 0; i < nb; i++) begin
      push(8, i == nb - 1);
      if (i < nb - 1) begin
        idle(4);
        chk(out_valid == 0, "R6 held", int'(out_valid), 0);
      end
    end
    idle(12);
    verify("R6 hold", 1, nb, 0, 0, 0);
    cfg_wait = 0;
  endtask

  task automatic t_cfg_change();
    clear();
    out_ready = 0;
    cfg_merge = 1; cfg_wide = 1; cfg_wait = 0;
    idle(2);
    for (int i = 0; i < 4; i++) push(9, i == 3);
    out_ready = 1;
    idle(2);
    cfg_merge = 0; cfg_wide = 0;
    idle(10);
    out_ready = 0;
    push(10, 0); push(10, 1);
    idle(3);
    out_ready = 1;
    idle(10);
    verify("R9 boundary", 3, 4, 1, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    idle(1);
    t_reset();
    t_batch("R2 no merge", 0, 0, 4, 4, 1, 1, 1, 1);
    t_batch("R3 128B", 1, 0, 4, 2, 2, 2, 0, 0);
    t_batch("R3 odd", 1, 0, 3, 2, 2, 1, 0, 0);
    t_batch("R4 256B", 1, 1, 4, 1, 4, 0, 0, 0);
    t_end_of_req();
    t_stream();
    t_hold(4);
    t_hold(2);
    t_cfg_change();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule